// File: doc/BRIEF.md
# Transmit Mailbox Scheduler

This block keeps three transmit mailboxes for a CAN-style controller and decides which waiting frame is handed to the bit-level transmitter next. Software fills a mailbox through a small write port: an identifier word, a length word and two data words. Setting bit 0 of the identifier word raises the transmit request and hands the mailbox to the scheduler. Per-mailbox empty, completed and success flags report progress. Completed flags are cleared by writing 1, and a per-mailbox abort withdraws a request.

The bus side holds one frame at a time on `tx_*` with `tx_valid` high until the transmitter returns a one-cycle result pulse that reports success or failure. A configuration bit selects the service order. In one setting the lowest identifier key goes first. In the other setting the oldest request goes first. A second bit turns off automatic retransmission. An interrupt line reports completed mailboxes when it is enabled.

Top module: `txmb_sched`

## Requirements
- R1: After reset all three mailboxes are empty (`st_empty`=3'b111), `st_done` and `st_ok` are zero, and `tx_valid` and `irq` are low.
- R2: `wr_sel` selects the word written: 0 is the identifier word, 1 is the length word (only bits 3:0 are kept), 2 is data bytes 0..3 (byte 0 in bits 7:0) and 3 is data bytes 4..7. Writing the identifier word with bit 0 set makes the mailbox non-empty. The frame is then presented on `tx_*`, with `tx_ident` equal to the written word with bit 0 cleared. While `tx_valid` is high and no result arrives, the frame and `tx_box` stay unchanged.
- R3: Any write to a mailbox that is not empty is ignored.
- R4: With `cfg_by_id`=1 the pending mailbox with the lowest key is sent first. When identifier bit 2 is 1, the key is identifier bits 31:3. When bit 2 is 0, the key is bits 31:21 followed by 18 zero bits. On equal keys the lower mailbox index wins.
- R5: With `cfg_by_id`=0, pending mailboxes are served in the order their requests were made. A retried mailbox keeps its original place.
- R6: A success result makes the sent mailbox empty with completed=1 and ok=1. Completed implies empty, and ok implies completed.
- R7: With `cfg_no_retry`=0, a failure result leaves the mailbox pending, and the mailbox is offered again.
- R8: With `cfg_no_retry`=1, a failure result makes the mailbox empty with completed=1 and ok=0, and the frame is not offered again.
- R9: An abort on a pending mailbox that is not being sent takes effect on the next clock edge: the mailbox becomes empty with completed=1 and ok=0. An abort on an empty mailbox changes nothing.
- R10: An abort on the mailbox being sent does not stop the attempt. A success still ends with ok=1. A failure ends with completed=1 and ok=0 and is not retried.
- R11: Writing 1 to a `done_clr` bit clears both completed and ok for that mailbox only.
- R12: `irq` is high exactly when `cfg_irq_en` is 1 and at least one completed flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_by_id | input | 1 | 1: serve by identifier key; 0: serve by request order |
| cfg_no_retry | input | 1 | 1: a failed attempt completes without retry |
| cfg_irq_en | input | 1 | Enables the completion interrupt |
| wr_en | input | 1 | Mailbox word write strobe |
| wr_box | input | 2 | Mailbox index 0..2 |
| wr_sel | input | 2 | Word select: 0 identifier, 1 length, 2 data low, 3 data high |
| wr_data | input | 32 | Write data |
| abort_req | input | 3 | Per-mailbox abort pulse |
| done_clr | input | 3 | Write-1-to-clear for completed and ok flags |
| st_empty | output | 3 | Mailbox empty flags |
| st_done | output | 3 | Request-completed flags |
| st_ok | output | 3 | Transmit-success flags |
| irq | output | 1 | Completion interrupt |
| tx_valid | output | 1 | A frame is offered to the transmitter |
| tx_box | output | 2 | Mailbox being sent |
| tx_ident | output | 32 | Identifier word of the offered frame, bit 0 zero |
| tx_len | output | 4 | Length code |
| tx_data_lo | output | 32 | Data bytes 0..3 |
| tx_data_hi | output | 32 | Data bytes 4..7 |
| res_valid | input | 1 | One-cycle result pulse from the transmitter |
| res_ok | input | 1 | Result: 1 success, 0 failure |

## Verification
The assertions assume that `res_valid` is a single-cycle pulse that arrives only while `tx_valid` is high, that `wr_box` never exceeds 2, and that the two mode bits change only while no frame is offered. The bench drives the transmitter side from one task, which waits for `tx_valid` before it pulses a result. It changes modes only between scenarios, after every mailbox has drained. Aborts and writes are issued only at chosen points, either during a transmission or while a mailbox waits.

// File: rtl/txmb_pkg.sv
package txmb_pkg;
    localparam int NUM_BOX = 3;
    localparam int BOX_W   = 2;
    localparam int WORD_W  = 32;
    localparam int LEN_W   = 4;
    localparam int KEY_W   = 29;
    localparam int STD_W   = 11;

    typedef enum logic [1:0] {
        SEL_IDENT = 2'd0,
        SEL_LEN   = 2'd1,
        SEL_DLO   = 2'd2,
        SEL_DHI   = 2'd3
    } word_sel_e;

    typedef enum logic {
        SCH_IDLE = 1'b0,
        SCH_SEND = 1'b1
    } sch_state_e;

    typedef struct packed {
        logic [WORD_W-1:0] ident;
        logic [LEN_W-1:0]  len;
        logic [WORD_W-1:0] dlo;
        logic [WORD_W-1:0] dhi;
    } frame_t;

    // Priority key: extended frames use all 29 bits, standard frames pad with zeros.
    function automatic logic [KEY_W-1:0] prio_key(input logic [WORD_W-1:0] ident);
        if (ident[2]) begin
            return ident[WORD_W-1:3];
        end
        return {ident[WORD_W-1:WORD_W-STD_W], {(KEY_W-STD_W){1'b0}}};
    endfunction
endpackage

// File: rtl/txmb_slot.sv
module txmb_slot
    import txmb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_hit,
    input  word_sel_e         wr_sel,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              abort_in,
    input  logic              clr_done,
    input  logic              in_flight,
    input  logic              res_here,
    input  logic              res_ok,
    input  logic              no_retry,
    output logic              pend,
    output logic              done,
    output logic              ok,
    output logic              req_pulse,
    output frame_t            frame
);
    logic accept;
    logic abort_hold;
    logic drop_now;
    logic fin_ok;
    logic fin_fail;

    assign accept    = wr_hit && !pend;
    assign req_pulse = accept && (wr_sel == SEL_IDENT) && wr_data[0];
    assign drop_now  = abort_in && pend && !in_flight;
    assign fin_ok    = res_here && res_ok;
    assign fin_fail  = res_here && !res_ok && (no_retry || abort_hold || abort_in);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend       <= 1'b0;
            done       <= 1'b0;
            ok         <= 1'b0;
            abort_hold <= 1'b0;
            frame      <= '0;
        end else begin
            if (accept) begin
                case (wr_sel)
                    SEL_IDENT: frame.ident <= {wr_data[WORD_W-1:1], 1'b0};
                    SEL_LEN:   frame.len   <= wr_data[LEN_W-1:0];
                    SEL_DLO:   frame.dlo   <= wr_data;
                    default:   frame.dhi   <= wr_data;
                endcase
            end
            if (req_pulse) begin
                pend       <= 1'b1;
                done       <= 1'b0;
                ok         <= 1'b0;
                abort_hold <= 1'b0;
            end else if (drop_now || fin_fail) begin
                pend       <= 1'b0;
                done       <= 1'b1;
                ok         <= 1'b0;
                abort_hold <= 1'b0;
            end else if (fin_ok) begin
                pend       <= 1'b0;
                done       <= 1'b1;
                ok         <= 1'b1;
                abort_hold <= 1'b0;
            end else begin
                if (clr_done) begin
                    done <= 1'b0;
                    ok   <= 1'b0;
                end
                if (abort_in && pend && in_flight) begin
                    abort_hold <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/txmb_age.sv
module txmb_age
    import txmb_pkg::*;
(
    input  logic                             clk,
    input  logic                             rst,
    input  logic [NUM_BOX-1:0]               req,
    output logic [NUM_BOX-1:0][NUM_BOX-1:0]  older
);
    // older[i][j] = 1 when mailbox i requested before mailbox j.
    always_ff @(posedge clk) begin
        if (rst) begin
            older <= '0;
        end else begin
            for (int i = 0; i < NUM_BOX; i++) begin
                if (req[i]) begin
                    for (int j = 0; j < NUM_BOX; j++) begin
                        if (j != i) begin
                            older[i][j] <= 1'b0;
                            older[j][i] <= 1'b1;
                        end
                    end
                end
            end
        end
    end
endmodule

// File: rtl/txmb_pick.sv
module txmb_pick
    import txmb_pkg::*;
(
    input  logic                             by_id,
    input  logic [NUM_BOX-1:0]               cand,
    input  logic [NUM_BOX-1:0][KEY_W-1:0]    keys,
    input  logic [NUM_BOX-1:0][NUM_BOX-1:0]  older,
    output logic                             grant_any,
    output logic [BOX_W-1:0]                 grant_idx
);
    logic [NUM_BOX-1:0] win;

    always_comb begin
        logic beat;
        win = '0;
        for (int i = 0; i < NUM_BOX; i++) begin
            win[i] = cand[i];
            for (int j = 0; j < NUM_BOX; j++) begin
                if (by_id) begin
                    beat = (keys[i] < keys[j]) || ((keys[i] == keys[j]) && (i <= j));
                end else begin
                    beat = older[i][j] || (i == j);
                end
                if (cand[j] && !beat) begin
                    win[i] = 1'b0;
                end
            end
        end
    end

    always_comb begin
        grant_idx = '0;
        for (int i = NUM_BOX - 1; i >= 0; i--) begin
            if (win[i]) begin
                grant_idx = BOX_W'(i);
            end
        end
    end

    assign grant_any = |win;
endmodule

// File: rtl/txmb_sched.sv
module txmb_sched
    import txmb_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_by_id,
    input  logic               cfg_no_retry,
    input  logic               cfg_irq_en,
    input  logic               wr_en,
    input  logic [BOX_W-1:0]   wr_box,
    input  logic [1:0]         wr_sel,
    input  logic [WORD_W-1:0]  wr_data,
    input  logic [NUM_BOX-1:0] abort_req,
    input  logic [NUM_BOX-1:0] done_clr,
    output logic [NUM_BOX-1:0] st_empty,
    output logic [NUM_BOX-1:0] st_done,
    output logic [NUM_BOX-1:0] st_ok,
    output logic               irq,
    output logic               tx_valid,
    output logic [BOX_W-1:0]   tx_box,
    output logic [WORD_W-1:0]  tx_ident,
    output logic [LEN_W-1:0]   tx_len,
    output logic [WORD_W-1:0]  tx_data_lo,
    output logic [WORD_W-1:0]  tx_data_hi,
    input  logic               res_valid,
    input  logic               res_ok
);
    sch_state_e                      state;
    logic [BOX_W-1:0]                cur;
    logic [NUM_BOX-1:0]              pend;
    logic [NUM_BOX-1:0]              req_pulse;
    logic [NUM_BOX-1:0]              in_flight;
    logic [NUM_BOX-1:0][KEY_W-1:0]   keys;
    logic [NUM_BOX-1:0][NUM_BOX-1:0] older;
    frame_t                          frames [NUM_BOX];
    frame_t                          tx_frame;
    logic                            grant_any;
    logic [BOX_W-1:0]                grant_idx;

    for (genvar i = 0; i < NUM_BOX; i++) begin : g_slot
        assign in_flight[i] = (state == SCH_SEND) && (cur == BOX_W'(i));
        assign keys[i]      = prio_key(frames[i].ident);

        txmb_slot u_slot (
            .clk       (clk),
            .rst       (rst),
            .wr_hit    (wr_en && (wr_box == BOX_W'(i))),
            .wr_sel    (word_sel_e'(wr_sel)),
            .wr_data   (wr_data),
            .abort_in  (abort_req[i]),
            .clr_done  (done_clr[i]),
            .in_flight (in_flight[i]),
            .res_here  (in_flight[i] && res_valid),
            .res_ok    (res_ok),
            .no_retry  (cfg_no_retry),
            .pend      (pend[i]),
            .done      (st_done[i]),
            .ok        (st_ok[i]),
            .req_pulse (req_pulse[i]),
            .frame     (frames[i])
        );
    end

    txmb_age u_age (
        .clk   (clk),
        .rst   (rst),
        .req   (req_pulse),
        .older (older)
    );

    // A mailbox aborted in this cycle is not a candidate.
    txmb_pick u_pick (
        .by_id     (cfg_by_id),
        .cand      (pend & ~abort_req),
        .keys      (keys),
        .older     (older),
        .grant_any (grant_any),
        .grant_idx (grant_idx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SCH_IDLE;
            cur   <= '0;
        end else begin
            case (state)
                SCH_IDLE: begin
                    if (grant_any) begin
                        cur   <= grant_idx;
                        state <= SCH_SEND;
                    end
                end
                default: begin
                    if (res_valid) begin
                        state <= SCH_IDLE;
                    end
                end
            endcase
        end
    end

    always_comb begin
        tx_frame = frames[0];
        for (int i = 1; i < NUM_BOX; i++) begin
            if (cur == BOX_W'(i)) begin
                tx_frame = frames[i];
            end
        end
    end

    assign st_empty   = ~pend;
    assign irq        = cfg_irq_en && (|st_done);
    assign tx_valid   = (state == SCH_SEND);
    assign tx_box     = cur;
    assign tx_ident   = tx_frame.ident;
    assign tx_len     = tx_frame.len;
    assign tx_data_lo = tx_frame.dlo;
    assign tx_data_hi = tx_frame.dhi;
endmodule

// File: rtl/txmb_sched_chk.sv
module txmb_sched_chk
    import txmb_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               cfg_no_retry,
    input logic               cfg_irq_en,
    input logic [NUM_BOX-1:0] abort_req,
    input logic [NUM_BOX-1:0] st_empty,
    input logic [NUM_BOX-1:0] st_done,
    input logic [NUM_BOX-1:0] st_ok,
    input logic               irq,
    input logic               tx_valid,
    input logic [BOX_W-1:0]   tx_box,
    input logic [WORD_W-1:0]  tx_ident,
    input logic               res_valid,
    input logic               res_ok
);
    p_hold_frame_r2: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !res_valid) |=> (tx_valid && $stable(tx_box) && $stable(tx_ident)));

    p_sent_pending_r2: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> !st_empty[tx_box]);

    p_success_r6: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && res_valid && res_ok) |=> (st_ok[$past(tx_box)] && !tx_valid));

    p_noretry_r8: assert property (@(posedge clk) disable iff (rst)
        (cfg_no_retry && tx_valid && res_valid && !res_ok)
        |=> (st_empty[$past(tx_box)] && st_done[$past(tx_box)] && !st_ok[$past(tx_box)]));

    p_irq_r12: assert property (@(posedge clk) disable iff (rst)
        irq |-> (cfg_irq_en && (st_done != '0)));

    for (genvar i = 0; i < NUM_BOX; i++) begin : g_box
        p_done_empty_r6: assert property (@(posedge clk) disable iff (rst)
            st_done[i] |-> st_empty[i]);

        p_ok_done_r6: assert property (@(posedge clk) disable iff (rst)
            st_ok[i] |-> st_done[i]);

        p_abort_idle_r9: assert property (@(posedge clk) disable iff (rst)
            (abort_req[i] && !st_empty[i] && !(tx_valid && (tx_box == BOX_W'(i))))
            |=> (st_empty[i] && st_done[i] && !st_ok[i]));
    end
endmodule

bind txmb_sched txmb_sched_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .cfg_no_retry (cfg_no_retry),
    .cfg_irq_en   (cfg_irq_en),
    .abort_req    (abort_req),
    .st_empty     (st_empty),
    .st_done      (st_done),
    .st_ok        (st_ok),
    .irq          (irq),
    .tx_valid     (tx_valid),
    .tx_box       (tx_box),
    .tx_ident     (tx_ident),
    .res_valid    (res_valid),
    .res_ok       (res_ok)
);

// File: tb/txmb_sched_test.sv
module txmb_sched_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_by_id = 1'b1;
    logic        cfg_no_retry = 1'b0;
    logic        cfg_irq_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_box = '0;
    logic [1:0]  wr_sel = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  abort_req = '0;
    logic [2:0]  done_clr = '0;
    logic [2:0]  st_empty, st_done, st_ok;
    logic        irq, tx_valid;
    logic [1:0]  tx_box;
    logic [31:0] tx_ident, tx_data_lo, tx_data_hi;
    logic [3:0]  tx_len;
    logic        res_valid = 1'b0;
    logic        res_ok = 1'b0;

    int n_chk = 0;
    int n_err = 0;

    always #2 clk = ~clk;

    txmb_sched uut (
        .clk(clk), .rst(rst), .cfg_by_id(cfg_by_id), .cfg_no_retry(cfg_no_retry),
        .cfg_irq_en(cfg_irq_en), .wr_en(wr_en), .wr_box(wr_box), .wr_sel(wr_sel),
        .wr_data(wr_data), .abort_req(abort_req), .done_clr(done_clr),
        .st_empty(st_empty), .st_done(st_done), .st_ok(st_ok), .irq(irq),
        .tx_valid(tx_valid), .tx_box(tx_box), .tx_ident(tx_ident), .tx_len(tx_len),
        .tx_data_lo(tx_data_lo), .tx_data_hi(tx_data_hi),
        .res_valid(res_valid), .res_ok(res_ok)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input int box, input int sel, input logic [31:0] data);
        wr_en = 1'b1; wr_box = 2'(box); wr_sel = 2'(sel); wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic load(input int box, input logic [31:0] ident, input logic [3:0] len,
                        input logic [31:0] dlo, input logic [31:0] dhi);
        wr(box, 1, {28'd0, len});
        wr(box, 2, dlo);
        wr(box, 3, dhi);
        wr(box, 0, ident | 32'd1);
    endtask

    task automatic wait_tx(input string tag);
        int n = 0;
        while (!tx_valid && n < 200) begin
            @(negedge clk);
            n++;
        end
        if (!tx_valid) chk({tag, " timeout"}, 32'(tx_valid), 32'd1);
    endtask

    task automatic respond(input logic good);
        res_valid = 1'b1; res_ok = good;
        @(negedge clk);
        res_valid = 1'b0;
    endtask

    task automatic pulse_abort(input logic [2:0] m);
        abort_req = m;
        @(negedge clk);
        abort_req = '0;
    endtask

    task automatic pulse_clr(input logic [2:0] m);
        done_clr = m;
        @(negedge clk);
        done_clr = '0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [31:0] id_a;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 empty", 32'(st_empty), 32'h7);
        chk("R1 done", 32'(st_done), 32'h0);
        chk("R1 ok", 32'(st_ok), 32'h0);
        chk("R1 tx_valid", 32'(tx_valid), 32'h0);
        chk("R1 irq", 32'(irq), 32'h0);

        // R2 loading and frame presentation
        id_a = (32'h2A5 << 21) | 32'h2;
        load(1, id_a, 4'h8, 32'h33221100, 32'h77665544);
        chk("R2 empty after request", 32'(st_empty), 32'h5);
        wait_tx("R2");
        chk("R2 box", 32'(tx_box), 32'd1);
        chk("R2 ident", tx_ident, id_a);
        chk("R2 len", 32'(tx_len), 32'h8);
        chk("R2 data lo", tx_data_lo, 32'h33221100);
        chk("R2 data hi", tx_data_hi, 32'h77665544);

        // R3 writes to a busy mailbox are ignored
        wr(1, 2, 32'hDEADBEEF);
        wr(1, 1, 32'h3);
        wr(1, 0, 32'h12345679);
        chk("R3 data lo kept", tx_data_lo, 32'h33221100);
        chk("R3 len kept", 32'(tx_len), 32'h8);
        chk("R3 ident kept", tx_ident, id_a);

        // R6 success
        respond(1'b1);
        chk("R6 ok1", 32'(st_ok), 32'h2);
        chk("R6 done1", 32'(st_done), 32'h2);
        chk("R6 empty", 32'(st_empty), 32'h7);
        chk("R6 tx_valid low", 32'(tx_valid), 32'h0);

        // R12 interrupt enable
        chk("R12 irq disabled", 32'(irq), 32'h0);
        cfg_irq_en = 1'b1;
        @(negedge clk);
        chk("R12 irq enabled", 32'(irq), 32'h1);
        pulse_clr(3'b010);
        chk("R12 irq after clear", 32'(irq), 32'h0);
        chk("R11 done cleared", 32'(st_done), 32'h0);

        // R7 retry
        load(0, 32'h100 << 21, 4'h1, 32'h1, 32'h2);
        wait_tx("R7 first");
        respond(1'b0);
        chk("R7 still pending", 32'(st_empty[0]), 32'h0);
        wait_tx("R7 again");
        chk("R7 reoffered box", 32'(tx_box), 32'd0);
        respond(1'b1);
        chk("R7 ok after retry", 32'(st_ok[0]), 32'h1);

        // R8 no retransmission
        cfg_no_retry = 1'b1;
        load(2, 32'h050 << 21, 4'h2, 32'h5, 32'h6);
        wait_tx("R8");
        respond(1'b0);
        chk("R8 empty", 32'(st_empty[2]), 32'h1);
        chk("R8 done", 32'(st_done[2]), 32'h1);
        chk("R8 ok clear", 32'(st_ok[2]), 32'h0);
        repeat (3) @(negedge clk);
        chk("R8 not reoffered", 32'(tx_valid), 32'h0);
        cfg_no_retry = 1'b0;

        // R11 clears only the chosen mailbox
        pulse_clr(3'b001);
        chk("R11 done only box2", 32'(st_done), 32'h4);
        chk("R11 ok cleared", 32'(st_ok), 32'h0);
        pulse_clr(3'b100);
        chk("R11 all clear", 32'(st_done), 32'h0);

        // R9 abort of a waiting mailbox, and of an empty one
        load(0, 32'h010 << 21, 4'h0, 32'h0, 32'h0);
        wait_tx("R9 hold");
        load(1, 32'h020 << 21, 4'h0, 32'h0, 32'h0);
        pulse_abort(3'b010);
        chk("R9 aborted empty", 32'(st_empty[1]), 32'h1);
        chk("R9 aborted done", 32'(st_done[1]), 32'h1);
        chk("R9 aborted ok", 32'(st_ok[1]), 32'h0);
        pulse_abort(3'b100);
        chk("R9 empty abort no effect done", 32'(st_done), 32'h2);
        chk("R9 empty abort no effect empty", 32'(st_empty), 32'h6);
        chk("R9 in-flight box unaffected", 32'(tx_valid), 32'h1);
        respond(1'b1);
        chk("R9 box0 ok", 32'(st_ok[0]), 32'h1);
        pulse_clr(3'b111);

        // R10 abort during transmission
        load(0, 32'h011 << 21, 4'h0, 32'h0, 32'h0);
        wait_tx("R10 fail");
        pulse_abort(3'b001);
        chk("R10 still offered", 32'(tx_valid), 32'h1);
        respond(1'b0);
        chk("R10 fail done", 32'(st_done[0]), 32'h1);
        chk("R10 fail ok", 32'(st_ok[0]), 32'h0);
        chk("R10 fail empty", 32'(st_empty[0]), 32'h1);
        repeat (3) @(negedge clk);
        chk("R10 no retry", 32'(tx_valid), 32'h0);
        load(1, 32'h012 << 21, 4'h0, 32'h0, 32'h0);
        wait_tx("R10 ok");
        pulse_abort(3'b010);
        respond(1'b1);
        chk("R10 success kept", 32'(st_ok[1]), 32'h1);
        pulse_clr(3'b111);

        // R5 request order, all six orders; identifiers favour the reverse order
        cfg_by_id = 1'b0;
        for (int p = 0; p < 6; p++) begin
            int ord [3];
            ord[0] = p / 2;
            ord[1] = (ord[0] + 1 + (p % 2)) % 3;
            ord[2] = 3 - ord[0] - ord[1];
            for (int k = 0; k < 3; k++) begin
                load(ord[k], (32'(10 - k)) << 21, 4'(k), 32'(k), 32'(p));
                if (k == 0) begin
                    wait_tx("R5 first");
                    chk("R5 first box", 32'(tx_box), 32'(ord[0]));
                end
            end
            respond(1'b0);
            for (int k = 0; k < 3; k++) begin
                wait_tx("R5 order");
                chk("R5 order", 32'(tx_box), 32'(ord[k]));
                respond(1'b1);
            end
            pulse_clr(3'b111);
        end

        // R4 identifier priority over all key triples, mixed formats, ties
        cfg_by_id = 1'b1;
        for (int v = 0; v < 27; v++) begin
            logic [28:0] key [3];
            logic [31:0] idw [3];
            logic [2:0]  left;
            int first;
            first = v % 3;
            for (int i = 0; i < 3; i++) begin
                int kv;
                bit ext;
                kv  = (v / (i == 0 ? 1 : (i == 1 ? 3 : 9))) % 3;
                ext = ((v + i) % 2) == 1;
                if (ext) begin
                    idw[i] = (32'(kv) << 21) | (32'd1 << 3) | 32'h4;
                    key[i] = (29'(kv) << 18) + 29'd1;
                end else begin
                    idw[i] = 32'(kv) << 21;
                    key[i] = 29'(kv) << 18;
                end
            end
            load(first, idw[first], 4'h1, 32'(v), 32'(v));
            wait_tx("R4 first");
            chk("R4 first box", 32'(tx_box), 32'(first));
            for (int i = 0; i < 3; i++) begin
                if (i != first) load(i, idw[i], 4'h1, 32'(v), 32'(v));
            end
            respond(1'b0);
            left = 3'b111;
            for (int r = 0; r < 3; r++) begin
                int best;
                best = -1;
                for (int i = 0; i < 3; i++) begin
                    if (left[i] && (best < 0 || key[i] < key[best])) best = i;
                end
                wait_tx("R4 round");
                chk("R4 priority", 32'(tx_box), 32'(best));
                left[best] = 1'b0;
                respond(1'b1);
            end
            pulse_clr(3'b111);
        end

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule